// File: doc/BRIEF.md
# 4:2:2 Byte-Stream Demultiplexer with Timing Recovery

This block takes a byte-wide 4:2:2 video stream, where one luma sample and one chroma sample arrive alternately on every byte clock, and splits it into whole pixels: one luma value with its co-sited Cb and Cr pair, produced once every two byte clocks. Each group of four bytes, counted from a line start, carries Cb, Y0, Cr, Y1. Both pixels of a group share that group's chroma pair.

Line and field timing comes from one of three sources, chosen by `mode_i`. The first decodes the timing-reference words carried in the stream itself. The second follows external horizontal and vertical strobes. The third is a free-running byte/line counter for 525-line or 625-line systems. The timing source sets the horizontal, vertical and field flags. It also sets the point where the four-byte group boundary is re-established.

Top module: `yc_demux_sync`

## Requirements
- R1: While `rst_n` is low the outputs are `pix_vld_o`=0, `y_o`=`cb_o`=`cr_o`=0, `h_o`=1, `v_o`=1 and `f_o`=0.
- R2: After alignment the bytes of a group are taken as Cb, Y0, Cr, Y1. The group produces two pixels in this order: (Y0, Cb, Cr) and then (Y1, Cb, Cr). Each pixel is presented on `y_o`/`cb_o`/`cr_o` in the same cycle as `pix_vld_o`.
- R3: `pix_vld_o` is never high on two consecutive clocks. A four-byte group with `h_o`=0 yields exactly two strobes.
- R4: `mode_i` 0 or 3 selects stream timing. A timing word is the byte sequence FF, 00, 00, XY, where XY bit 7 = 1, bit 6 = F, bit 5 = V and bit 4 = H. Bits 3..0 of XY are V^H, F^H, F^V and F^V^H. A valid word loads F, V and H into `f_o`, `v_o` and `h_o` one clock after XY. The byte following XY is taken as Cb.
- R5: A timing word whose XY has bit 7 = 0 or wrong bits 3..0 is ignored. The flags keep their values and no pixels appear because of it.
- R6: No pixel is formed from a group that starts while `h_o`=1. No pixel contains any byte of a timing word.
- R7: `mode_i`=1 selects strobe timing. `h_o` and `v_o` follow `hs_i` and `vs_i` one clock later. `f_o` toggles on each rising edge of `vs_i`. The byte present in the first clock with `hs_i` low is taken as Cb.
- R8: When `mode_i`=1, timing words in the stream leave `v_o` and `f_o` unchanged.
- R9: `mode_i`=2 selects the free-running counter. A line lasts LINE_BYTES_525 (1716) clocks with `std625_i`=0, or LINE_BYTES_625 (1728) clocks with `std625_i`=1. `h_o` is 0 for the first ACTIVE_BYTES (1440) bytes of a line, which gives ACTIVE_BYTES/2 pixel strobes per line.
- R10: With `mode_i`=2 a frame has LINES_525 or LINES_625 lines. `f_o` is 1 from line (lines+1)/2 to the end of the frame. `v_o` is 1 during the first VBLANK_LINES lines of each field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low reset |
| mode_i | input | 2 | Timing source: 0/3 stream words, 1 strobes, 2 free-running |
| std625_i | input | 1 | Free-running counter uses 625-line lengths when 1 |
| byte_i | input | DW | Multiplexed 4:2:2 byte stream |
| hs_i | input | 1 | External horizontal blanking strobe, high in blanking |
| vs_i | input | 1 | External vertical blanking strobe, high in blanking |
| pix_vld_o | output | 1 | One-clock pixel strobe |
| y_o | output | DW | Luma sample |
| cb_o | output | DW | Blue-difference sample |
| cr_o | output | DW | Red-difference sample |
| h_o | output | 1 | Horizontal blanking flag |
| v_o | output | 1 | Vertical blanking flag |
| f_o | output | 1 | Field flag |

## Verification
The assertions assume that `mode_i` changes only between lines. They also assume that active video inside a line comes in whole four-byte groups, so a timing word lands on the last slot of a group. The stimulus drives every active region as complete groups after a timing word or a falling `hs_i`. It uses data values between 10h and EFh, so payload bytes can never look like a timing word. It changes the mode or the line standard only while the block is in blanking. Misaligned filler runs are placed only in blanking, where they show the group boundary being re-established.

// File: rtl/yc_pkg.sv
package yc_pkg;

   typedef enum logic [1:0] {
      SYNC_TRS  = 2'd0,
      SYNC_EXT  = 2'd1,
      SYNC_FREE = 2'd2,
      SYNC_ALT  = 2'd3
   } sync_src_e;

   typedef struct packed {
      logic f;
      logic v;
      logic h;
   } tflags_t;

   // protection nibble expected for a given field/vertical/horizontal triple
   function automatic logic [3:0] prot_nibble(input logic f, input logic v, input logic h);
      return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

endpackage

// File: rtl/yc_trs_detect.sv
module yc_trs_detect
   import yc_pkg::*;
#(
   parameter int DW         = 8,
   parameter bit CHECK_PROT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] byte_i,
   output logic          hit_o,
   output tflags_t       flags_o
);

   logic [DW-1:0] hist1, hist2, hist3;
   logic          prefix_ok;
   logic          prot_ok;

   initial begin
      assert (DW >= 8) else $error("yc_trs_detect: DW must be at least 8");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist1 <= '0;
         hist2 <= '0;
         hist3 <= '0;
      end else begin
         hist1 <= byte_i;
         hist2 <= hist1;
         hist3 <= hist2;
      end
   end

   assign flags_o.f = byte_i[DW-2];
   assign flags_o.v = byte_i[DW-3];
   assign flags_o.h = byte_i[DW-4];

   assign prefix_ok = (&hist3) && (hist2 == '0) && (hist1 == '0) && byte_i[DW-1];

   generate
      if (CHECK_PROT) begin : g_prot
         assign prot_ok = (byte_i[DW-5:DW-8] ==
                           prot_nibble(byte_i[DW-2], byte_i[DW-3], byte_i[DW-4]));
      end else begin : g_noprot
         assign prot_ok = 1'b1;
      end
   endgenerate

   assign hit_o = prefix_ok && prot_ok;

endmodule

// File: rtl/yc_lane_split.sv
module yc_lane_split #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] byte_i,
   input  logic          sof_i,
   input  logic          kill_i,
   input  logic          blank_i,
   output logic          pix_vld_o,
   output logic [DW-1:0] y_o,
   output logic [DW-1:0] cb_o,
   output logic [DW-1:0] cr_o
);

   localparam logic [1:0] SLOT_CB = 2'd0;
   localparam logic [1:0] SLOT_Y0 = 2'd1;
   localparam logic [1:0] SLOT_CR = 2'd2;
   localparam logic [1:0] SLOT_Y1 = 2'd3;

   logic [1:0]    slot_q, slot;
   logic [DW-1:0] cb_c, y0_c, cr_c;
   logic [DW-1:0] y1_p, cb_p, cr_p;
   logic          pend_q;
   logic          emit0, emit1;

   assign slot  = sof_i ? SLOT_CB : slot_q;
   assign emit0 = (slot == SLOT_Y1) && !blank_i && !kill_i;
   assign emit1 = (slot == SLOT_Y0) && pend_q && !kill_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= SLOT_CB;
         cb_c   <= '0;
         y0_c   <= '0;
         cr_c   <= '0;
      end else begin
         slot_q <= slot + 2'd1;
         case (slot)
            SLOT_CB: cb_c <= byte_i;
            SLOT_Y0: y0_c <= byte_i;
            SLOT_CR: cr_c <= byte_i;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= 1'b0;
         y1_p      <= '0;
         cb_p      <= '0;
         cr_p      <= '0;
         pix_vld_o <= 1'b0;
         y_o       <= '0;
         cb_o      <= '0;
         cr_o      <= '0;
      end else begin
         pix_vld_o <= emit0 || emit1;
         if (emit0) begin
            y_o    <= y0_c;
            cb_o   <= cb_c;
            cr_o   <= cr_c;
            y1_p   <= byte_i;
            cb_p   <= cb_c;
            cr_p   <= cr_c;
            pend_q <= 1'b1;
         end else if (emit1) begin
            y_o    <= y1_p;
            cb_o   <= cb_p;
            cr_o   <= cr_p;
            pend_q <= 1'b0;
         end else if (kill_i || slot == SLOT_Y1) begin
            pend_q <= 1'b0;
         end
      end
   end

   AST_PIX_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      pix_vld_o |=> !pix_vld_o); // R3

endmodule

// File: rtl/yc_free_timer.sv
module yc_free_timer #(
   parameter int LB_A = 1716,
   parameter int LB_B = 1728,
   parameter int ACT  = 1440,
   parameter int LN_A = 525,
   parameter int LN_B = 625,
   parameter int VBL  = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic std_b_i,
   output logic sof_o,
   output logic h_o,
   output logic v_o,
   output logic f_o
);

   localparam int LBMAX = (LB_A > LB_B) ? LB_A : LB_B;
   localparam int LNMAX = (LN_A > LN_B) ? LN_A : LN_B;
   localparam int BW    = $clog2(LBMAX);
   localparam int LW    = $clog2(LNMAX);

   localparam logic [BW-1:0] BLAST_A = BW'(LB_A - 1);
   localparam logic [BW-1:0] BLAST_B = BW'(LB_B - 1);
   localparam logic [BW-1:0] ACT_L   = BW'(ACT);
   localparam logic [LW-1:0] LLAST_A = LW'(LN_A - 1);
   localparam logic [LW-1:0] LLAST_B = LW'(LN_B - 1);
   localparam logic [LW-1:0] F2_A    = LW'((LN_A + 1) / 2);
   localparam logic [LW-1:0] F2_B    = LW'((LN_B + 1) / 2);
   localparam logic [LW-1:0] VBL_L   = LW'(VBL);

   logic [BW-1:0] byte_cnt;
   logic [LW-1:0] line_cnt, line_in_fld;
   logic [BW-1:0] blast;
   logic [LW-1:0] llast, f2_start;
   logic          second_fld;

   initial begin
      assert (LB_A % 4 == 0 && LB_B % 4 == 0) else $error("yc_free_timer: line lengths must be whole groups");
      assert (ACT % 4 == 0 && ACT < LB_A && ACT < LB_B) else $error("yc_free_timer: bad active length");
      assert (LN_A > 2 * VBL && LN_B > 2 * VBL) else $error("yc_free_timer: bad blanking depth");
   end

   assign blast    = std_b_i ? BLAST_B : BLAST_A;
   assign llast    = std_b_i ? LLAST_B : LLAST_A;
   assign f2_start = std_b_i ? F2_B    : F2_A;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_cnt <= '0;
         line_cnt <= '0;
      end else if (byte_cnt >= blast) begin
         byte_cnt <= '0;
         line_cnt <= (line_cnt >= llast) ? '0 : line_cnt + 1'b1;
      end else begin
         byte_cnt <= byte_cnt + 1'b1;
      end
   end

   assign second_fld  = (line_cnt >= f2_start);
   assign line_in_fld = second_fld ? (line_cnt - f2_start) : line_cnt;

   assign sof_o = (byte_cnt == '0);
   assign h_o   = (byte_cnt >= ACT_L);
   assign v_o   = (line_in_fld < VBL_L);
   assign f_o   = second_fld;

   AST_LINE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(line_cnt) |-> byte_cnt == '0); // R9

   AST_VBLANK_AT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(f_o) |-> v_o); // R10

endmodule

// File: rtl/yc_demux_sync.sv
module yc_demux_sync
   import yc_pkg::*;
#(
   parameter int DW             = 8,
   parameter bit CHECK_PROT     = 1'b1,
   parameter int LINE_BYTES_525 = 1716,
   parameter int LINE_BYTES_625 = 1728,
   parameter int ACTIVE_BYTES   = 1440,
   parameter int LINES_525      = 525,
   parameter int LINES_625      = 625,
   parameter int VBLANK_LINES   = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    mode_i,
   input  logic          std625_i,
   input  logic [DW-1:0] byte_i,
   input  logic          hs_i,
   input  logic          vs_i,
   output logic          pix_vld_o,
   output logic [DW-1:0] y_o,
   output logic [DW-1:0] cb_o,
   output logic [DW-1:0] cr_o,
   output logic          h_o,
   output logic          v_o,
   output logic          f_o
);

   sync_src_e src;
   tflags_t   det_flags;
   logic      det_hit, use_trs, trs_ok, trs_ok_q;
   logic      hs_q, vs_q, hs_fall, vs_rise;
   logic      m_sof, m_h, m_v, m_f;
   logic      sof, blank;
   logic      h_q, v_q, f_q;

   assign src     = sync_src_e'(mode_i);
   assign use_trs = (src == SYNC_TRS) || (src == SYNC_ALT);

   yc_trs_detect #(
      .DW         (DW),
      .CHECK_PROT (CHECK_PROT)
   ) u_trs (
      .clk     (clk),
      .rst_n   (rst_n),
      .byte_i  (byte_i),
      .hit_o   (det_hit),
      .flags_o (det_flags)
   );

   yc_free_timer #(
      .LB_A (LINE_BYTES_525),
      .LB_B (LINE_BYTES_625),
      .ACT  (ACTIVE_BYTES),
      .LN_A (LINES_525),
      .LN_B (LINES_625),
      .VBL  (VBLANK_LINES)
   ) u_free (
      .clk     (clk),
      .rst_n   (rst_n),
      .std_b_i (std625_i),
      .sof_o   (m_sof),
      .h_o     (m_h),
      .v_o     (m_v),
      .f_o     (m_f)
   );

   assign trs_ok  = use_trs && det_hit;
   assign hs_fall = hs_q && !hs_i;
   assign vs_rise = vs_i && !vs_q;

   always_comb begin
      case (src)
         SYNC_EXT:  sof = hs_fall;
         SYNC_FREE: sof = m_sof;
         default:   sof = trs_ok_q;
      endcase
   end

   assign blank = (src == SYNC_FREE) ? m_h : h_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trs_ok_q <= 1'b0;
         hs_q     <= 1'b0;
         vs_q     <= 1'b0;
         h_q      <= 1'b1;
         v_q      <= 1'b1;
         f_q      <= 1'b0;
      end else begin
         trs_ok_q <= trs_ok;
         hs_q     <= hs_i;
         vs_q     <= vs_i;
         case (src)
            SYNC_EXT: begin
               h_q <= hs_i;
               v_q <= vs_i;
               if (vs_rise) f_q <= !f_q;
            end
            SYNC_FREE: begin
               h_q <= m_h;
               v_q <= m_v;
               f_q <= m_f;
            end
            default: begin
               if (trs_ok) begin
                  h_q <= det_flags.h;
                  v_q <= det_flags.v;
                  f_q <= det_flags.f;
               end
            end
         endcase
      end
   end

   yc_lane_split #(
      .DW (DW)
   ) u_lanes (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_i    (byte_i),
      .sof_i     (sof),
      .kill_i    (trs_ok),
      .blank_i   (blank),
      .pix_vld_o (pix_vld_o),
      .y_o       (y_o),
      .cb_o      (cb_o),
      .cr_o      (cr_o)
   );

   assign h_o = h_q;
   assign v_o = v_q;
   assign f_o = f_q;

   AST_TRS_LOADS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      trs_ok |=> ({f_q, v_q, h_q} == $past({det_flags.f, det_flags.v, det_flags.h}))); // R4

   AST_TRS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (use_trs && !trs_ok) |=> $stable({f_q, v_q, h_q})); // R5

   AST_TRS_NO_PIX: assert property (@(posedge clk) disable iff (!rst_n)
      trs_ok |=> !pix_vld_o); // R6

   AST_EXT_FIELD_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SYNC_EXT && vs_rise) |=> (f_q != $past(f_q))); // R7

   AST_EXT_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SYNC_EXT && !vs_rise) |=> $stable(f_q)); // R8

endmodule

// File: tb/yc_demux_sync_tb.sv
module yc_demux_sync_tb;

   localparam int LB5 = 24;
   localparam int LB6 = 28;
   localparam int ACT = 16;
   localparam int LN5 = 5;
   localparam int LN6 = 7;
   localparam int VBL = 1;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] mode_i;
   logic       std625_i;
   logic [7:0] byte_i;
   logic       hs_i, vs_i;
   logic       pix_vld_o, h_o, v_o, f_o;
   logic [7:0] y_o, cb_o, cr_o;

   int n_chk = 0;
   int n_bad = 0;
   bit sb_on = 1'b0;
   bit done  = 1'b0;
   logic [23:0] sb_q[$];

   always #10 clk = ~clk;

   yc_demux_sync #(
      .DW (8), .CHECK_PROT (1'b1),
      .LINE_BYTES_525 (LB5), .LINE_BYTES_625 (LB6), .ACTIVE_BYTES (ACT),
      .LINES_525 (LN5), .LINES_625 (LN6), .VBLANK_LINES (VBL)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .mode_i (mode_i), .std625_i (std625_i),
      .byte_i (byte_i), .hs_i (hs_i), .vs_i (vs_i),
      .pix_vld_o (pix_vld_o), .y_o (y_o), .cb_o (cb_o), .cr_o (cr_o),
      .h_o (h_o), .v_o (v_o), .f_o (f_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] xy(input logic f, input logic v, input logic h);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

   task automatic put(input logic [7:0] b);
      @(negedge clk);
      byte_i = b;
   endtask

   task automatic put_trs(input logic f, input logic v, input logic h);
      put(8'hFF); put(8'h00); put(8'h00); put(xy(f, v, h));
   endtask

   task automatic put_grp(input int i);
      logic [7:0] cb, y0, cr, y1;
      cb = 8'h40 + 8'(i); y0 = 8'h20 + 8'(2 * i); cr = 8'hA0 + 8'(i); y1 = 8'h21 + 8'(2 * i);
      sb_q.push_back({y0, cb, cr});
      sb_q.push_back({y1, cb, cr});
      put(cb); put(y0); put(cr); put(y1);
   endtask

   task automatic drain(input int n);
      repeat (n) put(8'h10);
   endtask

   // monitor: scoreboard pop and compare
   always @(negedge clk) begin
      if (sb_on && rst_n && pix_vld_o) begin
         if (sb_q.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R6 unexpected pixel actual=%0h expected=none", {y_o, cb_o, cr_o});
         end else begin
            check("R2 pixel content/order", {8'h0, y_o, cb_o, cr_o}, {8'h0, sb_q.pop_front()});
         end
      end
   end

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   task automatic measure_line(output int len, output int pix);
      do @(negedge clk); while (h_o !== 1'b0);
      do @(negedge clk); while (h_o !== 1'b1);
      len = 0; pix = 0;
      do begin @(negedge clk); len++; if (pix_vld_o) pix++; end while (h_o !== 1'b0);
      do begin @(negedge clk); len++; if (pix_vld_o) pix++; end while (h_o !== 1'b1);
   endtask

   task automatic measure_frame(output int len, output int fhi, output int vhi);
      do @(negedge clk); while (f_o !== 1'b0);
      do @(negedge clk); while (f_o !== 1'b1);
      len = 0; fhi = 1; vhi = (v_o === 1'b1) ? 1 : 0;
      do begin
         @(negedge clk); len++;
         if (f_o === 1'b1) fhi++;
         if (v_o === 1'b1) vhi++;
      end while (!(f_o === 1'b1 && fhi > 1 && len > 1 && prev_f == 1'b0));
      fhi--; if (v_o === 1'b1) vhi--;
   endtask

   logic prev_f;
   always @(negedge clk) prev_f <= f_o;

   initial begin
      int len, pix, fhi, vhi;
      rst_n = 1'b0; mode_i = 2'd0; std625_i = 1'b0; byte_i = 8'h10; hs_i = 1'b1; vs_i = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 reset pix_vld", pix_vld_o, 0);
      check("R1 reset y", y_o, 0);
      check("R1 reset h", h_o, 1);
      check("R1 reset v", v_o, 1);
      check("R1 reset f", f_o, 0);
      rst_n = 1'b1;
      sb_on = 1'b1;

      // stream timing, misaligned filler then start of active video
      put(8'h80); put(8'h10); put(8'h80); put(8'h10); put(8'h80);
      put_trs(1'b0, 1'b0, 1'b0);
      put_grp(0);
      check("R4 h after start word", h_o, 0);
      check("R4 v after start word", v_o, 0);
      check("R4 f after start word", f_o, 0);
      for (int i = 1; i < 6; i++) put_grp(i);
      put_trs(1'b0, 1'b0, 1'b1);
      put(8'h10);
      check("R4 h after end word", h_o, 1);
      drain(8);
      check("R2 all pixels emitted", sb_q.size(), 0);

      // corrupt protection bits: must be ignored
      put(8'hFF); put(8'h00); put(8'h00); put(8'h81);
      put(8'h10);
      check("R5 h kept on bad word", h_o, 1);
      put(8'h55); put(8'h66); put(8'h77); put(8'h44);
      put(8'h55); put(8'h66); put(8'h77); put(8'h44);
      drain(4);
      check("R5 no pixels from bad word", sb_q.size(), 0);

      // second field, vertical blanking line, odd filler before
      put(8'h80); put(8'h10);
      put_trs(1'b1, 1'b1, 1'b0);
      put_grp(10);
      check("R4 v loaded", v_o, 1);
      check("R4 f loaded", f_o, 1);
      put_grp(11); put_grp(12);
      put_trs(1'b1, 1'b1, 1'b1);
      put(8'h10);
      check("R6 h set by end word", h_o, 1);
      drain(6);
      check("R6 timing word bytes not emitted", sb_q.size(), 0);

      // external strobe timing
      @(negedge clk); mode_i = 2'd1; byte_i = 8'h10;
      drain(3);
      check("R7 h follows hs", h_o, 1);
      check("R7 v follows vs", v_o, 0);
      check("R7 f unchanged", f_o, 1);
      put(8'hFF); put(8'h00); put(8'h00); put(xy(1'b0, 1'b1, 1'b0));
      put(8'h10);
      check("R8 v not loaded from word", v_o, 0);
      check("R8 f not loaded from word", f_o, 1);
      put(8'h10); put(8'h80); put(8'h10);
      begin
         logic [7:0] cb, y0, cr, y1;
         cb = 8'h50; y0 = 8'h30; cr = 8'hB0; y1 = 8'h31;
         sb_q.push_back({y0, cb, cr});
         sb_q.push_back({y1, cb, cr});
         @(negedge clk); hs_i = 1'b0; byte_i = cb;
         put(y0); put(cr); put(y1);
      end
      check("R7 h low during active", h_o, 0);
      for (int i = 20; i < 24; i++) put_grp(i);
      @(negedge clk); hs_i = 1'b1; byte_i = 8'h10;
      drain(4);
      check("R7 h high after hs", h_o, 1);
      check("R2 external line pixels", sb_q.size(), 0);
      @(negedge clk); vs_i = 1'b1; byte_i = 8'h10;
      put(8'h10);
      check("R7 v follows vs rise", v_o, 1);
      check("R7 f toggles on vs rise", f_o, 0);
      @(negedge clk); vs_i = 1'b0;
      put(8'h10); put(8'h10);
      check("R7 f held on vs fall", f_o, 0);
      @(negedge clk); vs_i = 1'b1;
      put(8'h10); put(8'h10);
      check("R7 f toggles again", f_o, 1);

      // free-running counter
      sb_on = 1'b0;
      @(negedge clk); mode_i = 2'd2; std625_i = 1'b0;
      measure_line(len, pix);
      check("R9 line length 525", len, LB5);
      check("R9 pixels per line", pix, ACT / 2);
      std625_i = 1'b1;
      measure_line(len, pix);
      measure_line(len, pix);
      check("R9 line length 625", len, LB6);
      check("R9 pixels per line 625", pix, ACT / 2);
      measure_frame(len, fhi, vhi);
      measure_frame(len, fhi, vhi);
      check("R10 frame length 625", len, LN6 * LB6);
      check("R10 second field length 625", fhi, (LN6 - (LN6 + 1) / 2) * LB6);
      check("R10 vertical blanking 625", vhi, 2 * VBL * LB6);
      std625_i = 1'b0;
      measure_frame(len, fhi, vhi);
      measure_frame(len, fhi, vhi);
      check("R10 frame length 525", len, LN5 * LB5);
      check("R10 second field length 525", fhi, (LN5 - (LN5 + 1) / 2) * LB5);
      check("R10 vertical blanking 525", vhi, 2 * VBL * LB5);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule